// File: doc/BRIEF.md
# Segmented Video Memory Arbiter

This block sits between two requesters and a video memory built from several independent physical segments. The processor reads and writes, and the display refresh engine only reads. In every cycle the block works out which segment each requester addresses. When the two segments differ, both accesses go ahead in the same cycle, each on its own segment. When they are the same, the display wins that segment, so the picture never shows a glitch. The processor is then held by a wait line until the display moves to another segment.

The segment is chosen by the top address bits, and the number of segments is a power-of-two parameter. Smaller segments mean more of them and fewer collisions. For each segment the block drives a chip enable, a write enable, an owner select for that segment's address multiplexer, and the local (in-segment) address. These per-segment controls are registered: they appear at the segment one cycle after the request is accepted. The wait line is combinational, so the processor sees it in the same cycle as the collision.

Top module: `vmem_seg_arbiter`

## Requirements
- R1: The segment index is the top log2(SEG_CNT) bits of an address, and the local address sent to a segment is the remaining low bits. A lone request enables only the addressed segment, in the cycle after the request.
- R2: A display request always gets its segment in the next cycle: enable 1, owner select 0 (display), write enable 0, and the local address taken from the display address.
- R3: A processor request that does not collide is granted in the same cycle (wait 0). In the next cycle its segment has enable 1, owner select 1 (processor), the processor's local address, and write enable equal to the processor's write flag.
- R4: When both requesters address the same segment in a cycle, cpu_wait is 1 in that same cycle, and that segment serves the display in the next cycle.
- R5: cpu_wait is 1 only while the processor and the display request the same segment. It drops in the first cycle the display leaves that segment, and every held processor access then completes.
- R6: A write the processor issues while cpu_wait is 1 never raises any segment's write enable. It reaches the segment only in the cycle after the wait is released.
- R7: A segment addressed by neither granted requester has enable, write enable and owner select all 0. At most one segment writes in any cycle, and at most two are enabled.
- R8: With no processor request, or no display request, cpu_wait is 0.
- R9: While rst_n is low (synchronous, active low), cpu_wait is 0. In the cycle after a reset edge, every segment enable and write enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_req | input | 1 | Display refresh read request |
| disp_addr | input | ADDR_W | Display read address |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | Processor write flag (1 = write) |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wait | output | 1 | Processor hold, same cycle as a collision |
| seg_en | output | SEG_CNT | Per-segment chip enable |
| seg_cpu_sel | output | SEG_CNT | Per-segment address mux select, 1 = processor |
| seg_we | output | SEG_CNT | Per-segment write enable |
| seg_addr | output | SEG_CNT*LOC_W | Per-segment local address, segment i at bits [i*LOC_W +: LOC_W] |

## Verification
The hardest case to reach is a processor write that is held for several cycles while the display stays in the same segment, then moves away. The write must land exactly once, and only after the release. A directed sequence parks the display on one segment for several cycles while a held write waits, then moves the display elsewhere. An exhaustive sweep covers every pairing of request flags, write flag and segment indices. A long random run with a held-request processor then checks that every access completes within a bounded number of cycles.

// File: rtl/vmem_seg_pkg.sv
// Package: shared types for the segmented video memory arbiter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package vmem_seg_pkg;

    // Who drives a segment in a given cycle.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_DISP = 2'd1,
        OWN_CPU  = 2'd2
    } seg_owner_e;

endpackage

// File: rtl/vmem_seg_decode.sv
// Module: vmem_seg_decode
// Turns an address plus a request flag into a one-hot segment vector and
// the in-segment local address. The segment is the top SEG_W address bits.
// Assumes SEG_CNT is a power of two and at least 2.
module vmem_seg_decode #(
    parameter int ADDR_W  = 16,
    parameter int SEG_CNT = 8,
    localparam int SEG_W  = $clog2(SEG_CNT),
    localparam int LOC_W  = ADDR_W - SEG_W
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic [SEG_CNT-1:0] hit,
    output logic [LOC_W-1:0]  loc
);

    logic [SEG_W-1:0] seg_idx;

    // Split the address into segment index and local part.
    always_comb begin
        seg_idx = addr[ADDR_W-1 -: SEG_W];
        loc     = addr[LOC_W-1:0];
    end

    // One comparator per segment, qualified by the request.
    for (genvar g = 0; g < SEG_CNT; g++) begin : g_cmp
        always_comb hit[g] = req && (seg_idx == SEG_W'(g));
    end

endmodule

// File: rtl/vmem_seg_lane.sv
// Module: vmem_seg_lane
// Control for one physical segment. It picks the owner (display first),
// muxes the local address, and registers enable, select, write and address
// toward the segment. Assumes the caller has already removed a processor
// hit that collides with the display.
module vmem_seg_lane #(
    parameter int LOC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_hit,
    input  logic             cpu_hit,
    input  logic             cpu_we,
    input  logic [LOC_W-1:0] disp_loc,
    input  logic [LOC_W-1:0] cpu_loc,
    output logic             en_q,
    output logic             cpu_sel_q,
    output logic             we_q,
    output logic [LOC_W-1:0] addr_q
);
    import vmem_seg_pkg::*;

    seg_owner_e       owner;
    logic [LOC_W-1:0] addr_d;

    // Fixed priority: display over processor.
    always_comb begin
        if (disp_hit)     owner = OWN_DISP;
        else if (cpu_hit) owner = OWN_CPU;
        else              owner = OWN_NONE;
    end

    // Address multiplexer in front of the segment.
    always_comb addr_d = (owner == OWN_CPU) ? cpu_loc : disp_loc;

    // Register the segment controls; idle and zero in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            cpu_sel_q <= 1'b0;
            we_q      <= 1'b0;
            addr_q    <= '0;
        end else begin
            en_q      <= (owner != OWN_NONE);
            cpu_sel_q <= (owner == OWN_CPU);
            we_q      <= (owner == OWN_CPU) && cpu_we;
            addr_q    <= (owner == OWN_NONE) ? '0 : addr_d;
        end
    end

endmodule

// File: rtl/vmem_seg_arbiter.sv
// Module: vmem_seg_arbiter (top)
// Shares a segmented video memory between a processor port and a display
// read port. Both ports decode their segment each cycle, a collision is any
// segment both hit, and the processor is held with a combinational wait
// while it collides. Assumes the processor holds address and write flag
// stable while cpu_wait is high. SEG_CNT is a power of two and at least 2.
module vmem_seg_arbiter #(
    parameter int ADDR_W  = 16,
    parameter int SEG_CNT = 8,
    localparam int SEG_W  = $clog2(SEG_CNT),
    localparam int LOC_W  = ADDR_W - SEG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_req,
    input  logic [ADDR_W-1:0]        disp_addr,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    output logic                     cpu_wait,
    output logic [SEG_CNT-1:0]       seg_en,
    output logic [SEG_CNT-1:0]       seg_cpu_sel,
    output logic [SEG_CNT-1:0]       seg_we,
    output logic [SEG_CNT*LOC_W-1:0] seg_addr
);

    logic [SEG_CNT-1:0] disp_hit;
    logic [SEG_CNT-1:0] cpu_hit;
    logic [SEG_CNT-1:0] cpu_go_hit;
    logic [LOC_W-1:0]   disp_loc;
    logic [LOC_W-1:0]   cpu_loc;
    logic               clash;

    vmem_seg_decode #(.ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT)) disp_dec_i (
        .req  (disp_req),
        .addr (disp_addr),
        .hit  (disp_hit),
        .loc  (disp_loc)
    );

    vmem_seg_decode #(.ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT)) cpu_dec_i (
        .req  (cpu_req),
        .addr (cpu_addr),
        .hit  (cpu_hit),
        .loc  (cpu_loc)
    );

    // Collision: some segment is hit by both ports.
    always_comb clash = |(disp_hit & cpu_hit);

    // Wait generation, forced low in reset.
    always_comb cpu_wait = rst_n && clash;

    // Processor hits that may proceed this cycle.
    always_comb cpu_go_hit = (clash || !rst_n) ? '0 : cpu_hit;

    for (genvar g = 0; g < SEG_CNT; g++) begin : g_lane
        vmem_seg_lane #(.LOC_W(LOC_W)) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .disp_hit  (disp_hit[g]),
            .cpu_hit   (cpu_go_hit[g]),
            .cpu_we    (cpu_we),
            .disp_loc  (disp_loc),
            .cpu_loc   (cpu_loc),
            .en_q      (seg_en[g]),
            .cpu_sel_q (seg_cpu_sel[g]),
            .we_q      (seg_we[g]),
            .addr_q    (seg_addr[g*LOC_W +: LOC_W])
        );
    end

endmodule

// File: rtl/vmem_seg_arbiter_chk.sv
// Module: vmem_seg_arbiter_chk
// Property checker bound to vmem_seg_arbiter. It sees only the ports and
// keeps its own one-cycle copies of the requests to relate them to the
// registered segment controls.
module vmem_seg_arbiter_chk #(
    parameter int ADDR_W  = 16,
    parameter int SEG_CNT = 8,
    localparam int SEG_W  = $clog2(SEG_CNT)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               disp_req,
    input logic [ADDR_W-1:0]  disp_addr,
    input logic               cpu_req,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               cpu_wait,
    input logic [SEG_CNT-1:0] seg_en,
    input logic [SEG_CNT-1:0] seg_cpu_sel,
    input logic [SEG_CNT-1:0] seg_we
);

    logic [SEG_W-1:0] dseg, cseg, dseg_q, cseg_q;
    logic             dreq_q, cgo_q, cwait_q;

    // Segment indices seen at the ports.
    always_comb begin
        dseg = disp_addr[ADDR_W-1 -: SEG_W];
        cseg = cpu_addr[ADDR_W-1 -: SEG_W];
    end

    // One-cycle history of the requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq_q <= 1'b0; cgo_q <= 1'b0; cwait_q <= 1'b0;
            dseg_q <= '0;   cseg_q <= '0;
        end else begin
            dreq_q  <= disp_req;
            cgo_q   <= cpu_req && !cpu_wait;
            cwait_q <= cpu_wait;
            dseg_q  <= dseg;
            cseg_q  <= cseg;
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk)
        !rst_n |=> (seg_en == '0 && seg_we == '0)); // R9

    AST_WAIT_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req && cpu_req && dseg == cseg) |-> cpu_wait); // R4

    AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (disp_req && cpu_req && dseg == cseg)); // R5

    AST_NO_WAIT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_req || !cpu_req) |-> !cpu_wait); // R8

    AST_DISP_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q |-> (seg_en[dseg_q] && !seg_cpu_sel[dseg_q] && !seg_we[dseg_q])); // R2

    AST_CPU_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        cgo_q |-> (seg_en[cseg_q] && seg_cpu_sel[cseg_q])); // R3

    AST_WAIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cwait_q |-> !seg_we[cseg_q]); // R6

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_we)); // R7

    AST_EN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_en) <= 2); // R7

endmodule

bind vmem_seg_arbiter vmem_seg_arbiter_chk #(
    .ADDR_W  (ADDR_W),
    .SEG_CNT (SEG_CNT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_req    (disp_req),
    .disp_addr   (disp_addr),
    .cpu_req     (cpu_req),
    .cpu_addr    (cpu_addr),
    .cpu_wait    (cpu_wait),
    .seg_en      (seg_en),
    .seg_cpu_sel (seg_cpu_sel),
    .seg_we      (seg_we)
);

// File: tb/vmem_seg_arbiter_tb_top.sv
// Bench for vmem_seg_arbiter: exhaustive sweep on a 4-segment, 6-bit
// configuration, a directed held-write sequence, and a random phase.
module vmem_seg_arbiter_tb_top;
    localparam int ADDR_W  = 6;
    localparam int SEG_CNT = 4;
    localparam int SEG_W   = 2;
    localparam int LOC_W   = ADDR_W - SEG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_req = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] disp_addr = '0, cpu_addr = '0;
    logic cpu_wait;
    logic [SEG_CNT-1:0] seg_en, seg_cpu_sel, seg_we;
    logic [SEG_CNT*LOC_W-1:0] seg_addr;

    int n_chk = 0, n_fail = 0;
    logic [SEG_CNT-1:0] x_en, x_sel, x_we;
    logic [SEG_CNT*LOC_W-1:0] x_addr;

    always #2.5 clk = ~clk;

    vmem_seg_arbiter #(.ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .disp_addr(disp_addr),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wait(cpu_wait), .seg_en(seg_en), .seg_cpu_sel(seg_cpu_sel),
        .seg_we(seg_we), .seg_addr(seg_addr)
    );

    // Record one check.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected wait and next-cycle segment controls from the current inputs.
    function automatic logic exp_wait();
        return disp_req && cpu_req &&
               (disp_addr[ADDR_W-1 -: SEG_W] == cpu_addr[ADDR_W-1 -: SEG_W]);
    endfunction

    task automatic build_exp();
        int ds = int'(disp_addr[ADDR_W-1 -: SEG_W]);
        int cs = int'(cpu_addr[ADDR_W-1 -: SEG_W]);
        x_en = '0; x_sel = '0; x_we = '0; x_addr = '0;
        if (cpu_req && !exp_wait()) begin
            x_en[cs] = 1'b1; x_sel[cs] = 1'b1; x_we[cs] = cpu_we;
            x_addr[cs*LOC_W +: LOC_W] = cpu_addr[LOC_W-1:0];
        end
        if (disp_req) begin
            x_en[ds] = 1'b1;
            x_addr[ds*LOC_W +: LOC_W] = disp_addr[LOC_W-1:0];
        end
    endtask

    // Drive at negedge, check wait, then check registered outputs after posedge.
    task automatic step(input logic dr, input logic [ADDR_W-1:0] da,
                        input logic cr, input logic we, input logic [ADDR_W-1:0] ca,
                        input string tag);
        @(negedge clk);
        disp_req = dr; disp_addr = da; cpu_req = cr; cpu_we = we; cpu_addr = ca;
        #1;
        check({tag, " R4/R5/R8 wait"}, 32'(cpu_wait), 32'(exp_wait()));
        build_exp();
        @(posedge clk); #1;
        check({tag, " R1/R7 en"},    32'(seg_en),      32'(x_en));
        check({tag, " R2/R3 sel"},  32'(seg_cpu_sel), 32'(x_sel));
        check({tag, " R3/R6 we"},   32'(seg_we),      32'(x_we));
        check({tag, " R1 addr"},    32'(seg_addr),    32'(x_addr));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int stall;
        int done;
        // R9: reset state, with requests active and colliding.
        disp_req = 1'b1; cpu_req = 1'b1; cpu_we = 1'b1;
        disp_addr = 6'h21; cpu_addr = 6'h22;
        #1;
        check("R9 wait in reset", 32'(cpu_wait), 32'd0);
        repeat (3) @(posedge clk);
        #1;
        check("R9 en in reset", 32'(seg_en), 32'd0);
        check("R9 we in reset", 32'(seg_we), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1..R8: exhaustive sweep of flags and segment pairs.
        for (int dr = 0; dr < 2; dr++)
            for (int cr = 0; cr < 2; cr++)
                for (int we = 0; we < 2; we++)
                    for (int ds = 0; ds < SEG_CNT; ds++)
                        for (int cs = 0; cs < SEG_CNT; cs++)
                            step(1'(dr), {2'(ds), 4'($urandom)}, 1'(cr), 1'(we),
                                 {2'(cs), 4'($urandom)}, "sweep");

        // R5/R6: held write while display stays on segment 2, then leaves.
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 6'h25 + 6'(k), 1'b1, 1'b1, 6'h2A, "held");
            check("R6 no write while held", 32'(seg_we), 32'd0);
        end
        step(1'b1, 6'h03, 1'b1, 1'b1, 6'h2A, "release");
        check("R5 released write lands", 32'(seg_we), 32'b0100);
        step(1'b0, 6'h00, 1'b0, 1'b0, 6'h00, "idle");
        check("R7 idle all off", 32'(seg_en), 32'd0);

        // R5: random traffic; every processor access completes within a bound.
        done = 0; stall = 0;
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] ca = 6'($urandom);
            logic cwe = 1'($urandom);
            stall = 0;
            forever begin
                step(1'($urandom), 6'($urandom), 1'b1, cwe, ca, "random");
                if (exp_wait()) stall++;
                else break;
                if (stall > 40) break;
            end
            if (stall <= 40) done++;
        end
        check("R5 all accesses complete", 32'(done), 32'd3000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule